// File: doc/BRIEF.md
# CIF Video Downscaler

This block sits between a video decoder and a frame-buffer writer. It takes a byte-serial stream of 8-bit 4:2:2 video with a full-resolution active area of 720x576. A line-reference input is high during active samples, and a field-reference input tells the two interlaced fields apart. The block emits a CIF-sized picture in 4:1:1 chroma format. Each output byte comes with a valid strobe, and a one-cycle start pulse marks the beginning of every output frame.

The reduction uses counters and byte selection only, with no filter arithmetic. The sides of each active line are trimmed, and every second luma sample is kept. One Cb and one Cr survive for every four kept luma samples. Vertically, only the lines of one chosen field are passed, up to half the frame height.

Within a line, input bytes arrive as Cb, Y, Cr, Y, repeating from the first active byte. Output bytes leave as Cb, Y, Y, Cr, Y, Y per group. To produce that order, each group's Cr is parked in a register and replayed a few bytes later.

Top module: `cif_downscaler`

## Requirements
- R1: While reset is held, and in the first cycle after it, the outputs vout_valid, vout_sof and vout_data are all zero.
- R2: After reset, no byte is marked valid until the field reference has changed value at least once, even when active lines arrive.
- R3: Lines received while the field reference differs from KEEP_FIELD (default 0) never produce valid output.
- R4: In a kept line, the active bytes with index below 2*H_SKIP, or at or above 2*(ACT_PIX-H_SKIP), are never output. Byte index 0 is the first byte with the line reference high.
- R5: Let r be (index - 2*H_SKIP) mod 16 inside the window. The kept line's window bytes are output in this order per group: the byte at r=0 (Cb), r=1 (Y), r=5 (Y), the byte at r=2 (Cr), r=9 (Y), r=13 (Y). Each byte appears in the cycle after the input byte at r=0, 1, 5, 6, 9 and 13 respectively.
- R6: vout_valid is high only in the cycles listed in R5, giving exactly 6 valid bytes per 16 window bytes.
- R7: At most ACT_LINES/2 lines are kept per field; any further lines of the kept field produce no output.
- R8: vout_sof is a one-cycle pulse, issued in the cycle after the field reference changes to KEEP_FIELD. It therefore precedes the first kept byte of that field.
- R9: The byte index restarts at zero after every low period of the line reference, however short, and bytes with the line reference low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel byte clock |
| rst | input | 1 | Synchronous active-high reset |
| vin_data | input | 8 | Input video byte (Cb, Y, Cr, Y order) |
| vin_lref | input | 1 | Line reference, high on active bytes |
| vin_fref | input | 1 | Field reference, selects odd/even field |
| vout_data | output | 8 | Output 4:1:1 byte |
| vout_valid | output | 1 | High in cycles carrying a kept byte |
| vout_sof | output | 1 | One-cycle frame-start pulse |

## Verification
Two actions share one cycle at the byte with r=6. That byte is an incoming Cr that must be dropped, and in the same cycle the parked Cr captured at r=2 must be replayed. The bench gives every input byte a distinct value, so a design that forwards the live byte there instead of the held one shows a data mismatch at an exact, predicted cycle. The second overlap is at a field change: the field edge, the line-counter restart and the start pulse coincide. Repeated field toggles, and a reset in the middle of a kept field, check that the pulse appears exactly once and only for the kept field.

// File: rtl/cif_pkg.sv
package cif_pkg;

  typedef enum logic [1:0] {
    ROLE_NONE   = 2'd0,
    ROLE_PASS   = 2'd1,
    ROLE_HOLD   = 2'd2,
    ROLE_REPLAY = 2'd3
  } role_t;

  // Role of a window byte by its phase inside a 16-byte group.
  function automatic role_t role_of(input logic [3:0] ph);
    role_t r;
    case (ph)
      4'd0, 4'd1, 4'd5, 4'd9, 4'd13: r = ROLE_PASS;
      4'd2:                          r = ROLE_HOLD;
      4'd6:                          r = ROLE_REPLAY;
      default:                       r = ROLE_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cif_field_track.sv
module cif_field_track #(
  parameter int unsigned OUT_LINES  = 288,
  parameter bit          KEEP_FIELD = 1'b0,
  localparam int unsigned LW = $clog2(OUT_LINES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic fref,
  input  logic lref,
  output logic keep_line,
  output logic field_start
);

  logic          fref_q;
  logic          fvalid;
  logic          lref_q;
  logic          keep_f;
  logic [LW-1:0] lcnt;
  logic          fedge;

  assign fedge       = fvalid && (fref != fref_q);
  assign field_start = fedge && (fref == KEEP_FIELD);
  assign keep_line   = keep_f && (lcnt < LW'(OUT_LINES));

  always_ff @(posedge clk) begin
    if (rst) begin
      fref_q <= 1'b0;
      fvalid <= 1'b0;
      lref_q <= 1'b0;
      keep_f <= 1'b0;
      lcnt   <= '0;
    end else begin
      fvalid <= 1'b1;
      fref_q <= fref;
      lref_q <= lref;
      if (fedge) begin
        keep_f <= (fref == KEEP_FIELD);
        lcnt   <= '0;
      end else if (lref_q && !lref && (lcnt < LW'(OUT_LINES))) begin
        lcnt <= lcnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cif_line_pos.sv
module cif_line_pos #(
  parameter int unsigned ACT_PIX = 720,
  parameter int unsigned H_SKIP  = 8,
  localparam int unsigned LINE_BYTES = 2 * ACT_PIX,
  localparam int unsigned WIN_LO     = 2 * H_SKIP,
  localparam int unsigned WIN_HI     = 2 * (ACT_PIX - H_SKIP),
  localparam int unsigned BW         = $clog2(LINE_BYTES + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lref,
  output logic       in_win,
  output logic [3:0] phase
);

  logic [BW-1:0] bcnt;

  assign in_win = lref && (bcnt >= BW'(WIN_LO)) && (bcnt < BW'(WIN_HI));

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt  <= '0;
      phase <= '0;
    end else if (!lref) begin
      bcnt  <= '0;
      phase <= '0;
    end else begin
      if (bcnt < BW'(LINE_BYTES)) bcnt <= bcnt + 1'b1;
      if (in_win) phase <= phase + 1'b1;
    end
  end

endmodule

// File: rtl/cif_pick.sv
module cif_pick
  import cif_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  input  role_t         role,
  input  logic          keep,
  input  logic          start,
  output logic [DW-1:0] dout,
  output logic          dval,
  output logic          sof
);

  logic [DW-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
      dout <= '0;
      dval <= 1'b0;
      sof  <= 1'b0;
    end else begin
      dval <= 1'b0;
      sof  <= start;
      if (keep) begin
        case (role)
          ROLE_PASS: begin
            dout <= din;
            dval <= 1'b1;
          end
          ROLE_HOLD:   hold <= din;
          ROLE_REPLAY: begin
            dout <= hold;
            dval <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/cif_downscaler.sv
module cif_downscaler
  import cif_pkg::*;
#(
  parameter int unsigned ACT_PIX    = 720,
  parameter int unsigned ACT_LINES  = 576,
  parameter int unsigned H_SKIP     = 8,
  parameter bit          KEEP_FIELD = 1'b0,
  localparam int unsigned OUT_LINES = ACT_LINES / 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] vin_data,
  input  logic       vin_lref,
  input  logic       vin_fref,
  output logic [7:0] vout_data,
  output logic       vout_valid,
  output logic       vout_sof
);

  logic       keep_line;
  logic       field_start;
  logic       in_win;
  logic [3:0] phase;
  role_t      role;

  cif_field_track #(
    .OUT_LINES (OUT_LINES),
    .KEEP_FIELD(KEEP_FIELD)
  ) u_field (
    .clk        (clk),
    .rst        (rst),
    .fref       (vin_fref),
    .lref       (vin_lref),
    .keep_line  (keep_line),
    .field_start(field_start)
  );

  cif_line_pos #(
    .ACT_PIX(ACT_PIX),
    .H_SKIP (H_SKIP)
  ) u_pos (
    .clk   (clk),
    .rst   (rst),
    .lref  (vin_lref),
    .in_win(in_win),
    .phase (phase)
  );

  assign role = in_win ? role_of(phase) : ROLE_NONE;

  cif_pick #(
    .DW(8)
  ) u_pick (
    .clk  (clk),
    .rst  (rst),
    .din  (vin_data),
    .role (role),
    .keep (keep_line && in_win),
    .start(field_start),
    .dout (vout_data),
    .dval (vout_valid),
    .sof  (vout_sof)
  );

endmodule

// File: rtl/cif_downscaler_chk.sv
module cif_downscaler_chk #(
  parameter bit KEEP_FIELD = 1'b0
) (
  input logic clk,
  input logic rst,
  input logic vin_lref,
  input logic vin_fref,
  input logic vout_valid,
  input logic vout_sof
);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!vout_valid && !vout_sof));

  p_sof_single_r8: assert property (@(posedge clk) disable iff (rst)
    vout_sof |=> !vout_sof);

  p_sof_field_r8: assert property (@(posedge clk) disable iff (rst)
    vout_sof |-> ($past(vin_fref) == KEEP_FIELD));

  p_valid_needs_lref_r9: assert property (@(posedge clk) disable iff (rst)
    vout_valid |-> $past(vin_lref));

  p_sof_not_valid_r6: assert property (@(posedge clk) disable iff (rst)
    vout_sof |-> !vout_valid);

endmodule

bind cif_downscaler cif_downscaler_chk #(.KEEP_FIELD(KEEP_FIELD)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .vin_lref  (vin_lref),
  .vin_fref  (vin_fref),
  .vout_valid(vout_valid),
  .vout_sof  (vout_sof)
);

// File: tb/cif_downscaler_test.sv
`timescale 1ns/1ps
module cif_downscaler_test;

  localparam int AP = 24;
  localparam int AL = 8;
  localparam int HS = 4;
  localparam int OL = AL / 2;
  localparam bit KF = 1'b0;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lref = 1'b0;
  logic       fref = 1'b0;
  logic [7:0] din = 8'd0;
  logic [7:0] dout;
  logic       dval;
  logic       sof;

  always #4 clk = ~clk;

  cif_downscaler #(
    .ACT_PIX   (AP),
    .ACT_LINES (AL),
    .H_SKIP    (HS),
    .KEEP_FIELD(KF)
  ) uut (
    .clk       (clk),
    .rst       (rst),
    .vin_data  (din),
    .vin_lref  (lref),
    .vin_fref  (fref),
    .vout_data (dout),
    .vout_valid(dval),
    .vout_sof  (sof)
  );

  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 0;
  bit         pv = 0;
  bit         ps = 0;
  logic [7:0] pd = 8'd0;
  string      ptag = "R1";
  bit         fcur = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Check results of the previous byte, then drive the next one.
  task automatic tick(input bit r, input bit l, input bit f, input logic [7:0] d,
                      input bit ev, input logic [7:0] ed, input bit es,
                      input string tag);
    @(negedge clk);
    chk(dval === pv, ptag, "valid", int'(dval), int'(pv));
    chk(sof === ps, "R8", "sof", int'(sof), int'(ps));
    if (pv) chk(dout === pd, ptag, "data", int'(dout), int'(pd));
    rst = r; lref = l; fref = f; din = d;
    pv = ev; pd = ed; ps = es; ptag = tag;
  endtask

  function automatic logic [7:0] val(input int li, input int b);
    return 8'(li * 37 + b * 3 + 11);
  endfunction

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(0, 0, fcur, 8'd0, 0, 8'd0, 0, tag);
  endtask

  task automatic send_line(input int li, input bit kept, input string offtag,
                           input int gap);
    for (int b = 0; b < 2 * AP; b++) begin
      bit         ev = 0;
      logic [7:0] ed = 8'd0;
      string      tag = offtag;
      if (kept && b >= 2 * HS && b < 2 * (AP - HS)) begin
        int r = (b - 2 * HS) % 16;
        tag = "R6";
        if (r == 0 || r == 1 || r == 5 || r == 9 || r == 13) begin
          ev = 1; ed = val(li, b); tag = "R5";
        end else if (r == 6) begin
          ev = 1; ed = val(li, b - 4); tag = "R5";
        end
      end else if (kept) begin
        tag = "R4";
      end
      tick(0, 1, fcur, val(li, b), ev, ed, 0, tag);
    end
    idle(gap, "R9");
  endtask

  task automatic set_field(input bit f);
    bit es = (f == KF) && (f != fcur);
    fcur = f;
    tick(0, 0, f, 8'd0, 0, 8'd0, es, es ? "R8" : "R3");
    idle(2, "R3");
  endtask

  task automatic do_reset(input int n);
    for (int i = 0; i < n; i++) tick(1, 0, fcur, 8'd0, 0, 8'd0, 0, "R1");
    tick(0, 0, fcur, 8'd0, 0, 8'd0, 0, "R1");
    @(negedge clk);
    chk(dout === 8'd0 && dval === 1'b0 && sof === 1'b0, "R1", "reset outputs",
        int'({dout, dval, sof}), 0);
    pv = 0; ps = 0; ptag = "R1";
  endtask

  initial begin
    fcur = 1'b0;
    do_reset(4);
    idle(3, "R2");
    // R2: active lines before any field edge produce nothing
    send_line(0, 0, "R2", 4);
    send_line(1, 0, "R2", 4);
    // R3: other field is dropped
    set_field(1'b1);
    for (int i = 0; i < 4; i++) send_line(i, 0, "R3", 3);
    // R8, R5: kept field; R7: fifth line dropped
    set_field(1'b0);
    for (int i = 0; i < OL; i++) send_line(i, 1, "R5", 5);
    send_line(OL, 0, "R7", 5);
    send_line(OL + 1, 0, "R7", 5);
    set_field(1'b1);
    send_line(7, 0, "R3", 2);
    // R9: one-cycle blanking between kept lines
    set_field(1'b0);
    for (int i = 0; i < OL; i++) send_line(i + 10, 1, "R5", 1);
    send_line(20, 0, "R7", 1);
    // kept field again, then reset in the middle of it
    set_field(1'b1);
    set_field(1'b0);
    send_line(30, 1, "R5", 3);
    do_reset(2);
    idle(2, "R2");
    send_line(31, 0, "R2", 3);
    send_line(32, 0, "R2", 3);
    set_field(1'b1);
    send_line(33, 0, "R3", 3);
    set_field(1'b0);
    send_line(34, 1, "R5", 3);
    send_line(35, 1, "R5", 3);
    idle(4, "R6");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule